// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the low-order address bits for a fixed four-beat burst into a synchronous memory. A load request captures a base address. From then on, every clock edge on which the active-low advance input is low moves the sequence forward by one beat. When advance is high, the sequence holds, which suspends the burst. After the fourth beat the sequence wraps back to the captured base address instead of stopping.

A static mode input picks the beat order. In interleaved order, beat n is the base XOR n. In linear order, beat n is the base plus n, modulo the burst length. The upper address bits go around the sequencer unchanged. A last-beat flag marks the final beat of the four, so a bus controller can close or restart the burst.

Top module: `burst_seq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the stored base and the beat index. After that edge `burstAddr` is 0 and `lastBeat` is 0.
- R2: On a clock edge with `loadReq` high, `baseAddr` is captured and the beat index restarts at 0. After that edge `burstAddr` equals the captured base, so the first beat is not skipped. A load takes precedence over an advance in the same cycle and replaces any burst in progress.
- R3: With `interleaveMode` low (linear order), beat n drives `burstAddr = (base + n) mod 4`. For example, base 1 gives 1, 2, 3, 0.
- R4: With `interleaveMode` high (interleaved order), beat n drives `burstAddr = base XOR n`. For example, base 1 gives 1, 0, 3, 2.
- R5: The beat index steps by one only on a clock edge with `advanceN` low and `loadReq` low. On an edge with `advanceN` high and no load, `burstAddr` and `lastBeat` keep their values.
- R6: `lastBeat` is 1 exactly when the beat index is 3, which is the fourth beat after a load, and 0 on every other beat.
- R7: Advancing from the fourth beat returns `burstAddr` to the loaded base and clears `lastBeat`. The sequence then repeats.
- R8: `upperOut` always equals `upperIn` and is not registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| loadReq | input | 1 | Accepted address strobe; captures the base |
| baseAddr | input | 2 | Low address bits of the burst start |
| advanceN | input | 1 | Active-low burst advance |
| interleaveMode | input | 1 | 1 = interleaved order, 0 = linear order; held static |
| upperIn | input | 6 | Upper address bits from the requester |
| burstAddr | output | 2 | Current low address bits of the burst |
| upperOut | output | 6 | Upper address bits, passed through |
| lastBeat | output | 1 | High on the fourth beat of the burst |

## Verification
The bench covers every base value in both orders and walks each burst through two full wraps. A design that stopped at the fourth beat would fail here, and so would one that wrapped to zero instead of to the base. Suspension cycles are inserted part-way through each burst, which exposes a counter that moves while advance is high. The bench also reloads in the middle of a burst with advance asserted, which catches a design that lets the step win over the load or that leaves a stale beat index behind. A mode swap that used linear carry arithmetic for the interleaved order would give wrong addresses for bases 1 and 3, and the sweep covers both.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } seqStrb_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic     rst,
  input  logic     loadReq,
  input  logic     advanceN,
  output seqStrb_t strb
);
  // Priority: reset, then load, then step.
  always_comb begin
    strb.clear = rst;
    strb.load  = !rst && loadReq;
    strb.step  = !rst && !loadReq && !advanceN;
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_BITS = 2,
  parameter int UPPER_W   = 6
) (
  input  logic                 clk,
  input  seqStrb_t             strb,
  input  logic [ADDR_BITS-1:0] baseIn,
  input  logic                 interleave,
  input  logic [UPPER_W-1:0]   upperIn,
  output logic [ADDR_BITS-1:0] burstAddr,
  output logic [UPPER_W-1:0]   upperOut,
  output logic                 lastBeat
);
  localparam logic [ADDR_BITS-1:0] LAST_IDX = '1;

  logic [ADDR_BITS-1:0] baseReg;
  logic [ADDR_BITS-1:0] beatCnt;
  logic [ADDR_BITS-1:0] linAddr;
  logic [ADDR_BITS-1:0] intAddr;

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      baseReg <= '0;
      beatCnt <= '0;
    end else if (strb.load) begin
      baseReg <= baseIn;
      beatCnt <= '0;
    end else if (strb.step) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  assign linAddr = baseReg + beatCnt;

  for (genvar b = 0; b < ADDR_BITS; b++) begin : g_xorBit
    assign intAddr[b] = baseReg[b] ^ beatCnt[b];
  end

  assign burstAddr = interleave ? intAddr : linAddr;
  assign lastBeat  = (beatCnt == LAST_IDX);
  assign upperOut  = upperIn;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    strb.clear |=> (burstAddr == '0) && !lastBeat);

  // R2
  load_first_beat_chk: assert property (@(posedge clk) disable iff (strb.clear)
    strb.load |=> (burstAddr == $past(baseIn)) && !lastBeat);

  // R5
  suspend_hold_chk: assert property (@(posedge clk) disable iff (strb.clear)
    (!strb.load && !strb.step) |=> $stable(burstAddr) && $stable(lastBeat));

  // R7
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.step && lastBeat) |=> (burstAddr == baseReg) && !lastBeat);

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.step && !interleave && $stable(interleave)) |=>
      (burstAddr == ADDR_BITS'($past(burstAddr) + 1'b1)));
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int ADDR_BITS = 2,
  parameter int UPPER_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 loadReq,
  input  logic [ADDR_BITS-1:0] baseAddr,
  input  logic                 advanceN,
  input  logic                 interleaveMode,
  input  logic [UPPER_W-1:0]   upperIn,
  output logic [ADDR_BITS-1:0] burstAddr,
  output logic [UPPER_W-1:0]   upperOut,
  output logic                 lastBeat
);
  seqStrb_t strb;

  burst_seq_ctrl ctrl_i (
    .rst      (rst),
    .loadReq  (loadReq),
    .advanceN (advanceN),
    .strb     (strb)
  );

  burst_seq_dp #(.ADDR_BITS(ADDR_BITS), .UPPER_W(UPPER_W)) dp_i (
    .clk        (clk),
    .strb       (strb),
    .baseIn     (baseAddr),
    .interleave (interleaveMode),
    .upperIn    (upperIn),
    .burstAddr  (burstAddr),
    .upperOut   (upperOut),
    .lastBeat   (lastBeat)
  );
endmodule

// File: tb/burst_seq_top_tb.sv
module burst_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, loadReq, advanceN, interleaveMode;
  logic [1:0] baseAddr;
  logic [5:0] upperIn;
  logic [1:0] burstAddr;
  logic [5:0] upperOut;
  logic       lastBeat;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq_top dut_i (
    .clk(clk), .rst(rst), .loadReq(loadReq), .baseAddr(baseAddr),
    .advanceN(advanceN), .interleaveMode(interleaveMode), .upperIn(upperIn),
    .burstAddr(burstAddr), .upperOut(upperOut), .lastBeat(lastBeat)
  );

  function automatic logic [1:0] expAddr(logic m, logic [1:0] b, logic [1:0] n);
    return m ? (b ^ n) : 2'(b + n);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at the falling edge, apply one rising edge, sample at the next falling edge.
  task automatic cycle(logic ld, logic [1:0] b, logic advN);
    loadReq = ld; baseAddr = b; advanceN = advN;
    @(negedge clk);
  endtask

  task automatic beatCheck(string req, logic m, logic [1:0] b, logic [1:0] n);
    check(req, burstAddr, expAddr(m, b, n));
    check("R6", lastBeat, (n == 2'd3));
  endtask

  initial begin
    rst = 1'b1; loadReq = 1'b0; advanceN = 1'b1; interleaveMode = 1'b0;
    baseAddr = 2'd2; upperIn = 6'h15;
    @(negedge clk);
    @(negedge clk);
    check("R1", burstAddr, 0);
    check("R1", lastBeat, 0);
    rst = 1'b0;

    for (int m = 0; m < 2; m++) begin
      interleaveMode = m[0];
      for (int b = 0; b < 4; b++) begin
        logic [1:0] n;
        string req;
        req = m[0] ? "R4" : "R3";
        n = 2'd0;
        cycle(1'b1, 2'(b), 1'b1);
        beatCheck("R2", m[0], 2'(b), n);
        for (int s = 1; s <= 8; s++) begin
          if (s == 2 || s == 7) begin
            cycle(1'b0, 2'(3 - b), 1'b1);
            beatCheck("R5", m[0], 2'(b), n);
          end
          cycle(1'b0, 2'(3 - b), 1'b0);
          n = n + 2'd1;
          if (n == 2'd0) beatCheck("R7", m[0], 2'(b), n);
          else           beatCheck(req, m[0], 2'(b), n);
        end
      end
    end

    // R2: reload in mid-burst with advance asserted; load wins.
    interleaveMode = 1'b0;
    cycle(1'b1, 2'd1, 1'b0);
    cycle(1'b0, 2'd0, 1'b0);
    cycle(1'b0, 2'd0, 1'b0);
    cycle(1'b1, 2'd3, 1'b0);
    beatCheck("R2", 1'b0, 2'd3, 2'd0);
    cycle(1'b0, 2'd0, 1'b0);
    beatCheck("R3", 1'b0, 2'd3, 2'd1);

    // R1: reset in mid-burst.
    cycle(1'b0, 2'd0, 1'b0);
    cycle(1'b0, 2'd0, 1'b0);
    rst = 1'b1;
    cycle(1'b1, 2'd2, 1'b0);
    rst = 1'b0;
    check("R1", burstAddr, 0);
    check("R1", lastBeat, 0);

    // R8: pass-through of upper bits.
    for (int u = 0; u < 64; u += 7) begin
      upperIn = 6'(u);
      #1;
      check("R8", upperOut, u);
      @(negedge clk);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule